// File: doc/BRIEF.md
# Deep Sleep Entry and Wake Controller

This block sequences the low-power modes of a small microcontroller core. Software arms deep sleep through a guarded enable bit on a narrow register bus. The bit takes effect only after two writes, and it lapses on its own a few instruction cycles later. When the core raises its sleep strobe, the block checks how many instruction-cycle ticks have passed since the bit was armed. Inside the allowed window it enters deep sleep. Otherwise it enters ordinary sleep.

In deep sleep the system clock and peripheral enables are dropped. The calendar timer and the watchdog run from their own clocks outside this block. The regulator-enable input is sampled when the sleep strobe is taken, and it decides how the block leaves deep sleep. With retention, the core resumes at the next instruction. Without retention, the block raises a reset request. A six-bit sticky wake-source register records every source that fired. Two general-purpose retention registers keep their contents across any deep-sleep cycle.

Top module: `dslp_top`

## Requirements
- R1: Writing 1 to bit 0 of the control register (address 0) only arms a pending write. A second such write sets the enable bit, which reads back on bit 0 of address 0. The two writes need not be on consecutive cycles.
- R2: A pending first write is discarded on the 8th instruction tick after it. A write of 0 to bit 0 of address 0 clears the enable bit and cancels any pending write at once.
- R3: Once set, the enable bit clears itself on the 5th instruction tick after it was set.
- R4: A sleep strobe enters deep sleep only when the enable bit is set and 1 to 3 ticks have passed since it was set. Any other sleep strobe (enable clear, 0 ticks, or 4 ticks) enters ordinary sleep. Entering either sleep clears the enable bit.
- R5: In deep sleep, sysClkEn and periphEn are both 0 and sleepDeep is 1. In ordinary sleep, sysClkEn is 0, periphEn is 1 and sleepLight is 1.
- R6: If lvrEnable is 1 when the sleep strobe is taken, waking from deep sleep gives a one-cycle resumePulse. If it is 0, waking gives a one-cycle resetReq. The two never occur together.
- R7: Wake inputs are wakeSrc bit 0 master clear, bit 1 power-on, bit 2 calendar alarm, bit 3 external interrupt 0, bit 4 pin interrupt and bit 5 watchdog timeout. Each fired bit sets its own flag, read at address 1, bits 5:0. All bits that fire in the same cycle are recorded.
- R8: The wake flags clear on entry to deep sleep. They change only while in deep sleep, so they hold after wake. Writes to address 1 have no effect.
- R9: Suppose a wake input is seen in cycle w. Then sysClkEn and periphEn return to 1 in cycle w+1 with no exit strobe, and the exit strobe is high in cycle w+2 only.
- R10: Ordinary sleep ends on irqPending, with the same two-step timing as R9, and always ends with resumePulse.
- R11: Retention registers at addresses 2 and 3 hold the written values across deep sleep in both retention modes.
- R12: After reset, sysClkEn and periphEn are 1, no sleep or exit output is active, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycTick | input | 1 | One-cycle pulse per instruction cycle |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr |
| sleepStrobe | input | 1 | Core executed its sleep instruction |
| irqPending | input | 1 | Interrupt request that ends ordinary sleep |
| lvrEnable | input | 1 | Low-voltage regulator enabled (selects retention) |
| wakeSrc | input | 6 | Deep-sleep wake inputs, bit order as in R7 |
| sysClkEn | output | 1 | System clock enable |
| periphEn | output | 1 | Peripheral domain enable |
| sleepLight | output | 1 | Ordinary sleep active |
| sleepDeep | output | 1 | Deep sleep active |
| resumePulse | output | 1 | Resume at next instruction |
| resetReq | output | 1 | Restart from the reset vector |

## Verification
A wrong tick count in the arming or lifetime counters shows on bit 0 of address 0 on the next read. It also shows one sleep strobe later, as the wrong choice between sleepLight and sleepDeep. A wrong retention latch appears two cycles after a wake input, when resetReq fires instead of resumePulse or the reverse. A wake-flag register that fails to clear, or that keeps sampling after wake, shows as a wrong value at address 1 on the first read after entry or after a later input pulse.

// File: rtl/dslp_pkg.sv
package dslp_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_LIGHT,
    ST_DEEP,
    ST_RAMP,
    ST_EXIT
  } pwrState_t;

  typedef struct packed {
    logic sleepTaken;   // any sleep entered this cycle
    logic deepTaken;    // deep sleep entered this cycle
    logic wakeCapture;  // sample wake inputs into flags
  } ctlStrobe_t;

endpackage

// File: rtl/dslp_datapath.sv
module dslp_datapath
  import dslp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int WAKE_N   = 6,
  parameter int PEND_WIN = 8,
  parameter int EN_LIFE  = 5,
  parameter int WIN_LO   = 1,
  parameter int WIN_HI   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic              cycTick,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [WAKE_N-1:0] wakeSrc,
  output logic              deepWindow,
  output logic [DATA_W-1:0] regRdData
);

  localparam int GP_N  = 2;
  localparam int PCW   = $clog2(PEND_WIN + 1);
  localparam int AGEW  = $clog2(EN_LIFE + 1);
  localparam logic [PCW-1:0]  PEND_LAST = PCW'(PEND_WIN - 1);
  localparam logic [AGEW-1:0] AGE_LAST  = AGEW'(EN_LIFE - 1);
  localparam logic [AGEW-1:0] AGE_LO    = AGEW'(WIN_LO);
  localparam logic [AGEW-1:0] AGE_HI    = AGEW'(WIN_HI);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_WAKE  = ADDR_W'(1);

  logic            enableBit;
  logic            pending;
  logic [PCW-1:0]  pendCnt;
  logic [AGEW-1:0] enAge;
  logic [WAKE_N-1:0] wakeFlags;
  logic [DATA_W-1:0] gpReg [GP_N];

  logic ctrlWr, wrOne, wrZero;
  assign ctrlWr = regWrEn && (regAddr == A_CTRL);
  assign wrOne  = ctrlWr && regWrData[0];
  assign wrZero = ctrlWr && !regWrData[0];

  // guarded enable: double write, arming timeout, self-clearing lifetime
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableBit <= 1'b0;
      pending   <= 1'b0;
      pendCnt   <= '0;
      enAge     <= '0;
    end else if (ctl.sleepTaken || wrZero) begin
      enableBit <= 1'b0;
      pending   <= 1'b0;
    end else if (wrOne && pending) begin
      enableBit <= 1'b1;
      enAge     <= '0;
      pending   <= 1'b0;
    end else begin
      if (wrOne) begin
        pending <= 1'b1;
        pendCnt <= '0;
      end else if (cycTick && pending) begin
        if (pendCnt == PEND_LAST) pending <= 1'b0;
        else pendCnt <= pendCnt + 1'b1;
      end
      if (cycTick && enableBit) begin
        if (enAge == AGE_LAST) enableBit <= 1'b0;
        else enAge <= enAge + 1'b1;
      end
    end
  end

  assign deepWindow = enableBit && (enAge >= AGE_LO) && (enAge <= AGE_HI);

  // sticky wake-source flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               wakeFlags <= '0;
    else if (ctl.deepTaken)  wakeFlags <= '0;
    else if (ctl.wakeCapture) wakeFlags <= wakeFlags | wakeSrc;
  end

  // retention registers
  for (genvar g = 0; g < GP_N; g++) begin : gen_gp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) gpReg[g] <= '0;
      else if (regWrEn && regAddr == ADDR_W'(2 + g)) gpReg[g] <= regWrData;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_CTRL:     regRdData[0] = enableBit;
      A_WAKE:     regRdData[WAKE_N-1:0] = wakeFlags;
      ADDR_W'(2): regRdData = gpReg[0];
      ADDR_W'(3): regRdData = gpReg[1];
      default:    regRdData = '0;
    endcase
  end

  assert_set_needs_arm_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enableBit) |-> $past(pending) && $past(wrOne));

  assert_life_ends_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enableBit && cycTick && enAge == AGE_LAST && !wrOne) |=> !enableBit);

  assert_flags_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.deepTaken |=> (wakeFlags == '0));

  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.wakeCapture && !ctl.deepTaken) |=> $stable(wakeFlags));

endmodule

// File: rtl/dslp_control.sv
module dslp_control
  import dslp_pkg::*;
#(
  parameter int WAKE_N = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepStrobe,
  input  logic              irqPending,
  input  logic              lvrEnable,
  input  logic [WAKE_N-1:0] wakeSrc,
  input  logic              deepWindow,
  output ctlStrobe_t        ctl,
  output logic              sysClkEn,
  output logic              periphEn,
  output logic              sleepLight,
  output logic              sleepDeep,
  output logic              resumePulse,
  output logic              resetReq
);

  pwrState_t state, stateNxt;
  logic retain;

  always_comb begin
    ctl.sleepTaken  = (state == ST_RUN) && sleepStrobe;
    ctl.deepTaken   = ctl.sleepTaken && deepWindow;
    ctl.wakeCapture = (state == ST_DEEP);
  end

  always_comb begin
    stateNxt = state;
    case (state)
      ST_RUN:   if (sleepStrobe) stateNxt = deepWindow ? ST_DEEP : ST_LIGHT;
      ST_LIGHT: if (irqPending) stateNxt = ST_RAMP;
      ST_DEEP:  if (|wakeSrc) stateNxt = ST_RAMP;
      ST_RAMP:  stateNxt = ST_EXIT;
      default:  stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_RUN;
      retain <= 1'b1;
    end else begin
      state <= stateNxt;
      if (ctl.deepTaken)       retain <= lvrEnable;
      else if (ctl.sleepTaken) retain <= 1'b1;
    end
  end

  assign sleepLight  = (state == ST_LIGHT);
  assign sleepDeep   = (state == ST_DEEP);
  assign sysClkEn    = !(sleepLight || sleepDeep);
  assign periphEn    = !sleepDeep;
  assign resumePulse = (state == ST_EXIT) && retain;
  assign resetReq    = (state == ST_EXIT) && !retain;

  assert_deep_gates_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.deepTaken |=> (!sysClkEn && !periphEn));

  assert_one_exit_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(resumePulse && resetReq));

  assert_ramp_first_R9: assert property (@(posedge clk) disable iff (!rstN)
    (resumePulse || resetReq) |-> ($past(sysClkEn) && !$past(resumePulse || resetReq)));

  assert_light_resumes_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sleepLight && irqPending) |=> ##1 resumePulse);

endmodule

// File: rtl/dslp_top.sv
module dslp_top
  import dslp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int WAKE_N   = 6,
  parameter int PEND_WIN = 8,
  parameter int EN_LIFE  = 5,
  parameter int WIN_LO   = 1,
  parameter int WIN_HI   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycTick,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              sleepStrobe,
  input  logic              irqPending,
  input  logic              lvrEnable,
  input  logic [WAKE_N-1:0] wakeSrc,
  output logic              sysClkEn,
  output logic              periphEn,
  output logic              sleepLight,
  output logic              sleepDeep,
  output logic              resumePulse,
  output logic              resetReq
);

  ctlStrobe_t ctl;
  logic deepWindow;

  dslp_control #(.WAKE_N(WAKE_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .sleepStrobe(sleepStrobe), .irqPending(irqPending),
    .lvrEnable(lvrEnable), .wakeSrc(wakeSrc), .deepWindow(deepWindow), .ctl(ctl),
    .sysClkEn(sysClkEn), .periphEn(periphEn), .sleepLight(sleepLight),
    .sleepDeep(sleepDeep), .resumePulse(resumePulse), .resetReq(resetReq)
  );

  dslp_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WAKE_N(WAKE_N), .PEND_WIN(PEND_WIN),
    .EN_LIFE(EN_LIFE), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cycTick(cycTick), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .wakeSrc(wakeSrc),
    .deepWindow(deepWindow), .regRdData(regRdData)
  );

endmodule

// File: tb/dslp_top_tb.sv
`timescale 1ns/1ps
module dslp_top_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycTick = 1'b0, regWrEn = 1'b0, sleepStrobe = 1'b0, irqPending = 1'b0, lvrEnable = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [5:0] wakeSrc = '0;
  logic [7:0] regRdData;
  logic sysClkEn, periphEn, sleepLight, sleepDeep, resumePulse, resetReq;

  int checks = 0;
  int errors = 0;
  logic expQ[$];   // 1 = resume expected, 0 = reset expected
  logic prevClk = 1'b1;
  logic prevExit = 1'b0;

  always #2.5 clk = ~clk;

  dslp_top u_dut (
    .clk(clk), .rstN(rstN), .cycTick(cycTick), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sleepStrobe(sleepStrobe),
    .irqPending(irqPending), .lvrEnable(lvrEnable), .wakeSrc(wakeSrc),
    .sysClkEn(sysClkEn), .periphEn(periphEn), .sleepLight(sleepLight),
    .sleepDeep(sleepDeep), .resumePulse(resumePulse), .resetReq(resetReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected exit kinds when the design produces a strobe
  always @(negedge clk) begin
    if (rstN) begin
      if (resumePulse || resetReq) begin
        if (expQ.size() == 0) begin
          chk("R6 unexpected exit", {resumePulse, resetReq}, 0);
        end else begin
          logic want;
          want = expQ.pop_front();
          chk("R6 exit kind", {resumePulse, resetReq}, want ? 2'b10 : 2'b01);
          chk("R9 clock released one cycle earlier", {prevClk, prevExit}, 2'b10);
        end
      end
      prevClk  = sysClkEn;
      prevExit = resumePulse || resetReq;
    end
  end

  task automatic step(); @(negedge clk); endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      cycTick = 1'b1; step(); cycTick = 1'b0; step();
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d; step(); regWrEn = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    regAddr = a; #0.1; chk(req, regRdData, exp);
  endtask

  task automatic doSleep(); sleepStrobe = 1'b1; step(); sleepStrobe = 1'b0; endtask

  task automatic arm(); wr(2'd0, 8'h01); wr(2'd0, 8'h01); endtask

  // driver: wake and expect the exit kind through the scoreboard
  task automatic wake(input logic [5:0] src, input logic useIrq, input logic expResume);
    expQ.push_back(expResume);
    if (useIrq) irqPending = 1'b1; else wakeSrc = src;
    step();
    irqPending = 1'b0; wakeSrc = '0;
    chk("R9 clocks back in w+1", {sysClkEn, periphEn, resumePulse, resetReq}, 4'b1100);
    step();
    chk("R9 exit strobe in w+2", resumePulse || resetReq, 1);
    step();
    chk("R9 exit strobe one cycle", resumePulse || resetReq, 0);
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R12 reset state
    chk("R12 outputs", {sysClkEn, periphEn, sleepLight, sleepDeep, resumePulse, resetReq}, 6'b110000);
    rd("R12 ctrl", 2'd0, 8'h00);
    rd("R12 flags", 2'd1, 8'h00);
    rd("R12 gp0", 2'd2, 8'h00);

    // R1 double write, non-consecutive
    wr(2'd0, 8'h01);
    rd("R1 single write leaves bit clear", 2'd0, 8'h00);
    tick(2);
    wr(2'd0, 8'h01);
    rd("R1 second write sets", 2'd0, 8'h01);
    // R3 lifetime
    tick(4);
    rd("R3 still set after 4 ticks", 2'd0, 8'h01);
    tick(1);
    rd("R3 clear after 5th tick", 2'd0, 8'h00);

    // R2 pending expiry and cancel
    wr(2'd0, 8'h01); tick(8); wr(2'd0, 8'h01);
    rd("R2 expired first write", 2'd0, 8'h00);
    wr(2'd0, 8'h00); wr(2'd0, 8'h01);
    rd("R2 zero cancels pending", 2'd0, 8'h00);
    wr(2'd0, 8'h00);
    arm(); wr(2'd0, 8'h00);
    rd("R2 zero clears enable", 2'd0, 8'h00);

    // R11 retention values, then deep sleep without retention
    wr(2'd2, 8'hA5); wr(2'd3, 8'h3C);
    lvrEnable = 1'b0;
    arm(); tick(1); doSleep();
    chk("R4 deep at one tick", {sleepDeep, sleepLight}, 2'b10);
    chk("R5 deep gating", {sysClkEn, periphEn}, 2'b00);
    rd("R4 enable cleared on entry", 2'd0, 8'h00);
    lvrEnable = 1'b1;  // late change must not matter
    wake(6'b100000, 1'b0, 1'b0);
    rd("R7 watchdog flag", 2'd1, 8'h20);
    rd("R11 gp0 kept", 2'd2, 8'hA5);
    rd("R11 gp1 kept", 2'd3, 8'h3C);
    wr(2'd1, 8'hFF);
    rd("R8 flag write ignored", 2'd1, 8'h20);

    // deep with retention, clear on entry, simultaneous sources
    arm(); tick(2); doSleep();
    chk("R5 deep state", {sleepDeep, sysClkEn, periphEn}, 3'b100);
    rd("R8 flags cleared on entry", 2'd1, 8'h00);
    irqPending = 1'b1; step(); irqPending = 1'b0;
    chk("R5 irq ignored in deep", sleepDeep, 1);
    wake(6'b010100, 1'b0, 1'b1);
    rd("R7 two sources recorded", 2'd1, 8'h14);
    wakeSrc = 6'b001000; step(); wakeSrc = '0;
    rd("R8 flags hold after wake", 2'd1, 8'h14);

    // R4 window edges and R10 ordinary sleep
    arm(); doSleep();
    chk("R4 zero ticks gives ordinary", {sleepLight, sleepDeep}, 2'b10);
    chk("R5 ordinary gating", {sysClkEn, periphEn}, 2'b01);
    wakeSrc = 6'b000001; step(); wakeSrc = '0;
    chk("R10 wake input ignored in ordinary", sleepLight, 1);
    wake('0, 1'b1, 1'b1);
    arm(); tick(4); doSleep();
    chk("R4 four ticks gives ordinary", {sleepLight, sleepDeep}, 2'b10);
    wake('0, 1'b1, 1'b1);
    doSleep();
    chk("R4 enable clear gives ordinary", sleepLight, 1);
    wake('0, 1'b1, 1'b1);
    lvrEnable = 1'b0;
    arm(); tick(3); doSleep();
    chk("R4 three ticks gives deep", sleepDeep, 1);
    wake(6'b000011, 1'b0, 1'b0);
    rd("R7 master clear and power-on", 2'd1, 8'h03);

    repeat (3) step();
    chk("R6 all expected exits seen", expQ.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule